// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers interrupt requests for a small processor core and hands the core one request at a time, together with the address of the vector word to fetch. Peripheral requests arrive as pairs of status flag and enable bits. Each pair is mapped to an interrupt number, and several pairs may share a number. Sources that have no enable bit depend on their flag alone. Three special sources sit above them in a fixed order: a software trap pulse, a bad-opcode pulse and a non-maskable request line. The non-maskable line is gated only by the core's X mask bit. The peripheral numbers are gated by the core's I mask bit and ranked through a priority-order table that software can rewrite.

The controller runs a two-state machine. In `ST_WATCH` it arbitrates every cycle. When a request is serviceable it raises `take_stb` for one cycle, along with the interrupt number, the vector address and a request to set either X or I. That is the transition `WATCH->SERVICE`. It then stays in `ST_SERVICE` to cover the service overhead. The transition `SERVICE->WATCH` fires once the overhead count expires, so two takes are always at least 14 cycles apart. A peripheral's pending bit is rebuilt every cycle from its flags, so a take does not remove it, and it asserts again until the device clears its flag.

Top module: `prio_vec_intc`

## Requirements
- R1: After reset the pending mask is empty, the priority table is the identity order (slot k holds number k), the state is `ST_WATCH`, and `irq_valid`, `take_stb`, `set_i_req` and `set_x_req` are 0.
- R2: Source s (bit s of `dev_flag`/`dev_en`) is pending when its flag and enable are both 1. A source whose `SRC_HAS_EN` bit is 0 is pending on its flag alone. In the default map, sources 0-3 map to number 3, source 4 to 4, source 5 to 5, source 6 to 6 and source 7 to 7, and sources 6 and 7 have no enable.
- R3: A number shared by several sources is pending while at least one of them is active, whatever the state of the others.
- R4: The software trap (number 0) ranks above the bad-opcode trap (number 1). Both are taken regardless of `mask_i` and `mask_x`. A take clears only the bit it serviced, and a new pulse in the take cycle sets the bit again.
- R5: The non-maskable request (number 2) is latched while `nmi_lvl` is high. It ranks above every peripheral number, is taken only when `mask_x` is 0, and is cleared by its take.
- R6: With `mask_i` = 1 no peripheral number (3 and up) is selected. Otherwise the first pending number found when walking the priority table from slot 0 is selected. A write (`ord_we`, `ord_slot`, `ord_id`) replaces one slot at the next edge.
- R7: Taking a peripheral number does not clear it. If its flag is still active, it is taken again when the service window ends.
- R8: `vec_addr` equals base + 2 x `irq_id`. The base is 0xFFC0, or 0xBFC0 when `boot_alt` is high during reset.
- R9: With each take, `set_x_req` is 1 when the number is 2, and `set_i_req` is 1 for every other number. Both are 0 outside a take.
- R10: A take moves the state from `ST_WATCH` to `ST_SERVICE`. No take or valid indication occurs until 14 cycles after the previous take, and requests that arrive meanwhile are kept.
- R11: When nothing is serviceable, or during `ST_SERVICE`, `irq_valid` is 0 and `irq_id` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boot_alt | input | 1 | Selects the alternate vector base when sampled at reset |
| dev_flag | input | N_SRC | Peripheral status flags |
| dev_en | input | N_SRC | Peripheral enable bits |
| swt_pulse | input | 1 | Software trap request |
| badop_pulse | input | 1 | Bad-opcode trap request |
| nmi_lvl | input | 1 | Non-maskable request line |
| mask_i | input | 1 | Core I mask bit |
| mask_x | input | 1 | Core X mask bit |
| ord_we | input | 1 | Priority table write strobe |
| ord_slot | input | ID_W | Priority table slot to write |
| ord_id | input | ID_W | Interrupt number written to the slot |
| irq_valid | output | 1 | A request is being taken this cycle |
| irq_id | output | ID_W | Number being taken, 0 when not valid |
| vec_addr | output | AW | Address of the vector word |
| take_stb | output | 1 | One-cycle take strobe |
| set_i_req | output | 1 | Request that the core set I |
| set_x_req | output | 1 | Request that the core set X |

## Verification
A new request can arrive in the same cycle as a take. A software trap pulse is driven in the cycle in which a peripheral number is taken, and another in the cycle in which the trap itself is taken. The bench then checks that the trap waits out the full 14-cycle window, wins the next arbitration, and is taken a second time after the re-pulse. It also checks that the peripheral number, whose flag never dropped, is taken once the traps are gone.

// File: rtl/intc_pkg.sv
package intc_pkg;
    localparam int unsigned ID_W = 5;
    localparam int unsigned AW   = 16;
    localparam int NUM_SWT   = 0;
    localparam int NUM_BADOP = 1;
    localparam int NUM_NMI   = 2;
    localparam int NUM_FIRST_MASKABLE = 3;
    localparam logic [AW-1:0] VBASE_NORM = 16'hFFC0;
    localparam logic [AW-1:0] VBASE_ALT  = 16'hBFC0;

    typedef enum logic [0:0] {
        ST_WATCH   = 1'b0,
        ST_SERVICE = 1'b1
    } intc_state_e;
endpackage

// File: rtl/intc_pend_collect.sv
module intc_pend_collect
    import intc_pkg::*;
#(
    parameter int N_SRC = 8,
    parameter int N_ID  = 8,
    parameter logic [N_SRC*ID_W-1:0] SRC_MAP = '0,
    parameter logic [N_SRC-1:0] SRC_HAS_EN = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_SRC-1:0] dev_flag,
    input  logic [N_SRC-1:0] dev_en,
    input  logic            swt_pulse,
    input  logic            badop_pulse,
    input  logic            nmi_lvl,
    input  logic            take,
    input  logic [ID_W-1:0] take_id,
    output logic [N_ID-1:0] pend
);
    logic [N_SRC-1:0] src_act;
    logic [N_ID-1:0]  set_m;
    logic [N_ID-1:0]  clr_m;

    always_comb begin
        src_act = dev_flag & (dev_en | ~SRC_HAS_EN);
        set_m = '0;
        clr_m = '0;
        // shared numbers: drop on any idle contributor, then re-add on any active one
        for (int d = NUM_FIRST_MASKABLE; d < N_ID; d++) begin
            for (int s = 0; s < N_SRC; s++) begin
                if (SRC_MAP[s*ID_W +: ID_W] == ID_W'(d)) begin
                    if (src_act[s]) set_m[d] = 1'b1;
                    else            clr_m[d] = 1'b1;
                end
            end
        end
        for (int d = 0; d < NUM_FIRST_MASKABLE; d++) begin
            if (take && take_id == ID_W'(d)) clr_m[d] = 1'b1;
        end
        set_m[NUM_SWT]   = swt_pulse;
        set_m[NUM_BADOP] = badop_pulse;
        set_m[NUM_NMI]   = nmi_lvl;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= (pend & ~clr_m) | set_m;
    end
endmodule

// File: rtl/intc_order_table.sv
module intc_order_table
    import intc_pkg::*;
#(
    parameter int N_ID = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ord_we,
    input  logic [ID_W-1:0]      ord_slot,
    input  logic [ID_W-1:0]      ord_id,
    output logic [N_ID*ID_W-1:0] ord_flat
);
    genvar k;
    generate
        for (k = 0; k < N_ID; k++) begin : g_slot
            always_ff @(posedge clk) begin
                if (!rst_n)
                    ord_flat[k*ID_W +: ID_W] <= ID_W'(k);
                else if (ord_we && ord_slot == ID_W'(k))
                    ord_flat[k*ID_W +: ID_W] <= ord_id;
            end
        end
    endgenerate
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter
    import intc_pkg::*;
#(
    parameter int N_ID = 8
) (
    input  logic [N_ID-1:0]      pend,
    input  logic [N_ID*ID_W-1:0] ord_flat,
    input  logic                 mask_i,
    input  logic                 mask_x,
    output logic                 sel_valid,
    output logic [ID_W-1:0]      sel_id
);
    logic [ID_W-1:0] cand;

    always_comb begin
        sel_valid = 1'b0;
        sel_id    = '0;
        cand      = '0;
        if (pend[NUM_SWT]) begin
            sel_valid = 1'b1;
            sel_id    = ID_W'(NUM_SWT);
        end else if (pend[NUM_BADOP]) begin
            sel_valid = 1'b1;
            sel_id    = ID_W'(NUM_BADOP);
        end else if (pend[NUM_NMI] && !mask_x) begin
            sel_valid = 1'b1;
            sel_id    = ID_W'(NUM_NMI);
        end else if (!mask_i) begin
            for (int k = 0; k < N_ID; k++) begin
                cand = ord_flat[k*ID_W +: ID_W];
                for (int d = NUM_FIRST_MASKABLE; d < N_ID; d++) begin
                    if (!sel_valid && cand == ID_W'(d) && pend[d]) begin
                        sel_valid = 1'b1;
                        sel_id    = ID_W'(d);
                    end
                end
            end
        end
    end
endmodule

// File: rtl/prio_vec_intc.sv
module prio_vec_intc
    import intc_pkg::*;
#(
    parameter int N_SRC   = 8,
    parameter int N_ID    = 8,
    parameter int SVC_CYC = 14,
    parameter logic [N_SRC*ID_W-1:0] SRC_MAP =
        {5'd7, 5'd6, 5'd5, 5'd4, 5'd3, 5'd3, 5'd3, 5'd3},
    parameter logic [N_SRC-1:0] SRC_HAS_EN = 8'b0011_1111
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             boot_alt,
    input  logic [N_SRC-1:0] dev_flag,
    input  logic [N_SRC-1:0] dev_en,
    input  logic             swt_pulse,
    input  logic             badop_pulse,
    input  logic             nmi_lvl,
    input  logic             mask_i,
    input  logic             mask_x,
    input  logic             ord_we,
    input  logic [ID_W-1:0]  ord_slot,
    input  logic [ID_W-1:0]  ord_id,
    output logic             irq_valid,
    output logic [ID_W-1:0]  irq_id,
    output logic [AW-1:0]    vec_addr,
    output logic             take_stb,
    output logic             set_i_req,
    output logic             set_x_req
);
    localparam int CNT_W = $clog2(SVC_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(SVC_CYC - 2);

    intc_state_e         state;
    logic [CNT_W-1:0]    svc_cnt;
    logic [AW-1:0]       vbase;
    logic [N_ID-1:0]     pend;
    logic [N_ID*ID_W-1:0] ord_flat;
    logic                sel_valid;
    logic [ID_W-1:0]     sel_id;

    intc_pend_collect #(
        .N_SRC(N_SRC), .N_ID(N_ID), .SRC_MAP(SRC_MAP), .SRC_HAS_EN(SRC_HAS_EN)
    ) u_pend (
        .clk(clk), .rst_n(rst_n), .dev_flag(dev_flag), .dev_en(dev_en),
        .swt_pulse(swt_pulse), .badop_pulse(badop_pulse), .nmi_lvl(nmi_lvl),
        .take(take_stb), .take_id(irq_id), .pend(pend)
    );

    intc_order_table #(.N_ID(N_ID)) u_order (
        .clk(clk), .rst_n(rst_n), .ord_we(ord_we), .ord_slot(ord_slot),
        .ord_id(ord_id), .ord_flat(ord_flat)
    );

    intc_arbiter #(.N_ID(N_ID)) u_arb (
        .pend(pend), .ord_flat(ord_flat), .mask_i(mask_i), .mask_x(mask_x),
        .sel_valid(sel_valid), .sel_id(sel_id)
    );

    // state register: WATCH->SERVICE on a take, SERVICE->WATCH when the overhead expires
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_WATCH;
            svc_cnt <= '0;
            vbase   <= boot_alt ? VBASE_ALT : VBASE_NORM;
        end else begin
            unique case (state)
                ST_WATCH: begin
                    if (sel_valid) begin
                        state   <= ST_SERVICE;
                        svc_cnt <= CNT_LOAD;
                    end
                end
                ST_SERVICE: begin
                    if (svc_cnt == '0) state <= ST_WATCH;
                    else               svc_cnt <= svc_cnt - 1'b1;
                end
                default: state <= ST_WATCH;
            endcase
        end
    end

    // outputs
    always_comb begin
        irq_valid = 1'b0;
        irq_id    = '0;
        unique case (state)
            ST_WATCH: begin
                irq_valid = sel_valid;
                irq_id    = sel_valid ? sel_id : '0;
            end
            ST_SERVICE: begin
                irq_valid = 1'b0;
                irq_id    = '0;
            end
            default: ;
        endcase
        take_stb  = irq_valid;
        vec_addr  = vbase + (AW'(irq_id) << 1);
        set_x_req = irq_valid && (irq_id == ID_W'(NUM_NMI));
        set_i_req = irq_valid && (irq_id != ID_W'(NUM_NMI));
    end
endmodule

// File: rtl/prio_vec_intc_chk.sv
module prio_vec_intc_chk
    import intc_pkg::*;
#(
    parameter int SVC_CYC = 14
) (
    input logic            clk,
    input logic            rst_n,
    input logic            mask_i,
    input logic            mask_x,
    input logic            irq_valid,
    input logic [ID_W-1:0] irq_id,
    input logic [AW-1:0]   vec_addr,
    input logic            take_stb,
    input logic            set_i_req,
    input logic            set_x_req
);
    localparam int GW = $clog2(SVC_CYC + 1);
    logic [GW-1:0] gap;

    always_ff @(posedge clk) begin
        if (!rst_n)                    gap <= GW'(SVC_CYC);
        else if (take_stb)             gap <= GW'(1);
        else if (gap < GW'(SVC_CYC))   gap <= gap + 1'b1;
    end

    assert_take_spacing_R10: assert property (@(posedge clk) disable iff (!rst_n)
        take_stb |-> gap >= GW'(SVC_CYC));
    assert_take_lone_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        take_stb |=> !take_stb);
    assert_nmi_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (take_stb && irq_id == ID_W'(NUM_NMI)) |-> !mask_x);
    assert_imask_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (take_stb && irq_id >= ID_W'(NUM_FIRST_MASKABLE)) |-> !mask_i);
    assert_one_set_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        take_stb |-> $countones({set_i_req, set_x_req}) == 1);
    assert_vec_offset_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> vec_addr[ID_W:0] == {irq_id, 1'b0});
    assert_idle_id_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_valid |-> (irq_id == '0 && !set_i_req && !set_x_req));
endmodule

bind prio_vec_intc prio_vec_intc_chk #(.SVC_CYC(SVC_CYC)) u_chk (
    .clk(clk), .rst_n(rst_n), .mask_i(mask_i), .mask_x(mask_x),
    .irq_valid(irq_valid), .irq_id(irq_id), .vec_addr(vec_addr),
    .take_stb(take_stb), .set_i_req(set_i_req), .set_x_req(set_x_req)
);

// File: tb/prio_vec_intc_test.sv
module prio_vec_intc_test;
    localparam int CLK_PERIOD = 10;
    localparam int SVC = 14;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       boot_alt = 1'b0;
    logic [7:0] dev_flag = '0;
    logic [7:0] dev_en = '0;
    logic       swt_pulse = 1'b0, badop_pulse = 1'b0, nmi_lvl = 1'b0;
    logic       mask_i = 1'b0, mask_x = 1'b0;
    logic       ord_we = 1'b0;
    logic [4:0] ord_slot = '0, ord_id = '0;
    logic       irq_valid, take_stb, set_i_req, set_x_req;
    logic [4:0] irq_id;
    logic [15:0] vec_addr;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    prio_vec_intc uut (
        .clk(clk), .rst_n(rst_n), .boot_alt(boot_alt), .dev_flag(dev_flag),
        .dev_en(dev_en), .swt_pulse(swt_pulse), .badop_pulse(badop_pulse),
        .nmi_lvl(nmi_lvl), .mask_i(mask_i), .mask_x(mask_x), .ord_we(ord_we),
        .ord_slot(ord_slot), .ord_id(ord_id), .irq_valid(irq_valid),
        .irq_id(irq_id), .vec_addr(vec_addr), .take_stb(take_stb),
        .set_i_req(set_i_req), .set_x_req(set_x_req)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // expect a take of number id at this sample point, with base
    task automatic chk_take(input string req, input int id, input int base);
        chk(req, "valid", int'(irq_valid), 1);
        chk(req, "take", int'(take_stb), 1);
        chk(req, "id", int'(irq_id), id);
        chk(req, "vec", int'(vec_addr), base + 2*id);
        chk(req, "set_x", int'(set_x_req), (id == 2) ? 1 : 0);
        chk(req, "set_i", int'(set_i_req), (id == 2) ? 0 : 1);
    endtask

    task automatic chk_idle(input string req);
        chk(req, "valid", int'(irq_valid), 0);
        chk(req, "take", int'(take_stb), 0);
        chk(req, "id", int'(irq_id), 0);
    endtask

    task automatic wait_n(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    // {flag, en, mask_i, mask_x, exp_valid, exp_id}
    localparam int NV = 10;
    localparam logic [23:0] VEC [NV] = '{
        {8'h01, 8'h00, 1'b0, 1'b0, 1'b0, 5'd0},  // R2 flag without enable
        {8'h01, 8'h01, 1'b0, 1'b0, 1'b1, 5'd3},  // R2 flag and enable
        {8'h08, 8'h08, 1'b0, 1'b0, 1'b1, 5'd3},  // R3 other contributor of number 3
        {8'h30, 8'h30, 1'b0, 1'b0, 1'b1, 5'd4},  // R6 identity order picks 4 over 5
        {8'h30, 8'h30, 1'b1, 1'b0, 1'b0, 5'd0},  // R6 I mask blocks peripherals
        {8'h40, 8'h00, 1'b0, 1'b0, 1'b1, 5'd6},  // R2 source with no enable
        {8'h80, 8'h00, 1'b1, 1'b0, 1'b0, 5'd0},  // R6 masked no-enable source
        {8'hA0, 8'h20, 1'b0, 1'b0, 1'b1, 5'd5},  // R6 5 ahead of 7
        {8'h0F, 8'h00, 1'b0, 1'b1, 1'b0, 5'd0},  // R11 nothing serviceable
        {8'h06, 8'h04, 1'b0, 1'b1, 1'b1, 5'd3}   // R3 one of two flags enabled, X ignored
    };

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        wait_n(3);
        // R1 / R11 reset state
        chk_idle("R1");
        chk("R1", "set_i", int'(set_i_req), 0);
        chk("R1", "set_x", int'(set_x_req), 0);
        rst_n = 1'b1;
        wait_n(2);
        chk_idle("R11");

        // vector table
        for (int v = 0; v < NV; v++) begin
            dev_flag = VEC[v][23:16];
            dev_en   = VEC[v][15:8];
            mask_i   = VEC[v][7];
            mask_x   = VEC[v][6];
            @(negedge clk);
            if (VEC[v][5]) chk_take($sformatf("R2/R3/R6 vec%0d", v), int'(VEC[v][4:0]), 16'hFFC0);
            else           chk_idle($sformatf("R11 vec%0d", v));
            dev_flag = '0; dev_en = '0; mask_i = 1'b0; mask_x = 1'b0;
            wait_n(SVC);
        end

        // R7 re-take while flag held; R10 no valid during service
        dev_flag = 8'h10; dev_en = 8'h10;
        @(negedge clk);
        chk_take("R7 first", 4, 16'hFFC0);
        @(negedge clk);
        chk_idle("R10 in service");
        wait_n(SVC - 2);
        chk_idle("R10 last service cycle");
        @(negedge clk);
        chk_take("R7 again", 4, 16'hFFC0);
        dev_flag = '0; dev_en = '0;
        wait_n(SVC);

        // R4 traps ignore masks, order soft trap then bad opcode
        mask_i = 1'b1; mask_x = 1'b1;
        dev_flag = 8'h10; dev_en = 8'h10;
        swt_pulse = 1'b1; badop_pulse = 1'b1;
        @(negedge clk);
        swt_pulse = 1'b0; badop_pulse = 1'b0;
        chk_take("R4 soft trap", 0, 16'hFFC0);
        wait_n(SVC);
        chk_take("R4 bad opcode", 1, 16'hFFC0);
        wait_n(SVC);
        chk_idle("R4 cleared by take");
        dev_flag = '0; dev_en = '0;

        // R5 non-maskable line held off by X
        nmi_lvl = 1'b1;
        @(negedge clk);
        nmi_lvl = 1'b0;
        chk_idle("R5 X set");
        @(negedge clk);
        chk_idle("R5 still held");
        mask_x = 1'b0;
        #1;
        chk_take("R5 X clear", 2, 16'hFFC0);
        @(negedge clk);
        wait_n(SVC - 1);
        chk_idle("R5 cleared by take");

        // R5 beats peripherals; R9 set-I after peripheral
        mask_i = 1'b0;
        dev_flag = 8'h10; dev_en = 8'h10; nmi_lvl = 1'b1;
        @(negedge clk);
        nmi_lvl = 1'b0;
        chk_take("R5 over peripheral", 2, 16'hFFC0);
        wait_n(SVC);
        chk_take("R9 peripheral after nmi", 4, 16'hFFC0);
        dev_flag = '0; dev_en = '0;
        wait_n(SVC);

        // R10 trap arriving in a take cycle; re-pulse in its own take cycle
        dev_flag = 8'h20; dev_en = 8'h20;
        @(negedge clk);
        chk_take("R10 peripheral", 5, 16'hFFC0);
        swt_pulse = 1'b1;
        @(negedge clk);
        swt_pulse = 1'b0;
        chk_idle("R10 trap waits");
        wait_n(SVC - 1);
        chk_take("R10 trap after window", 0, 16'hFFC0);
        swt_pulse = 1'b1;
        @(negedge clk);
        swt_pulse = 1'b0;
        wait_n(SVC - 1);
        chk_take("R4 re-pulse in take cycle", 0, 16'hFFC0);
        wait_n(SVC);
        chk_take("R7 peripheral kept", 5, 16'hFFC0);
        dev_flag = '0; dev_en = '0;
        wait_n(SVC);

        // R6 programmable order: slot 0 gets number 5
        ord_we = 1'b1; ord_slot = 5'd0; ord_id = 5'd5;
        @(negedge clk);
        ord_we = 1'b0;
        dev_flag = 8'h21; dev_en = 8'h21;
        @(negedge clk);
        chk_take("R6 reordered", 5, 16'hFFC0);
        dev_flag = '0; dev_en = '0;
        wait_n(SVC);

        // R8 alternate base; R1 reset restores identity order
        rst_n = 1'b0; boot_alt = 1'b1;
        wait_n(2);
        rst_n = 1'b1; boot_alt = 1'b0;
        dev_flag = 8'h21; dev_en = 8'h21;
        @(negedge clk);
        chk_take("R8 alt base, R1 identity", 3, 16'hBFC0);
        dev_flag = '0; dev_en = '0;
        wait_n(SVC);

        finish_run();
    end
endmodule